// File: doc/BRIEF.md
# Branch and Call Sequencing Unit

This block decides where an 8-bit processor with a 16-bit address space goes next after a control-transfer instruction. The fetch logic presents an opcode in the range 0x20 to 0x2A with a one-cycle `start` pulse. It also presents up to two operand bytes, the address of the opcode and the current carry, zero and sign flags. The unit then works through a small state machine and produces the next program counter with a one-cycle `done` strobe. Branch targets are absolute 16-bit values. They are never offsets from the current address.

Subroutine support uses an external return-address stack with 16-bit entries. A call pushes its return address. A return, or an interrupt return, pops one entry. The interrupt return also pulses `ie_restore` so the interrupt logic can re-enable interrupts. The register-indirect jump reads its target from an even-aligned register pair through an asynchronous register-file read port. The low byte comes from the even address and the high byte from the odd address after it.

States: `ST_IDLE` waits for an accepted instruction. `ST_HOLD` is the second cycle of a direct jump or call. `ST_RDLO` and `ST_RDHI` read the two bytes of an indirect target. `ST_FIN` is the completion cycle, in which `done` is high. Transitions: IDLE→HOLD on a branch or call, IDLE→FIN on a return, an interrupt return or an odd indirect pointer, IDLE→RDLO on an even indirect pointer, HOLD→FIN, RDLO→RDHI, RDHI→FIN, FIN→IDLE.

Top module: `branch_seq_top`

## Requirements
- R1: Opcodes 0x20/0x21 jump when carry is 1/0, 0x22/0x23 when zero is 1/0, and 0x24/0x25 when sign is 1/0. A taken jump sets `pc_next` to `{op_hi, op_lo}`.
- R2: A conditional jump that is not taken sets `pc_next` to `pc_in + 3`, wrapping modulo 2^16.
- R3: Opcode 0x26 always loads `{op_hi, op_lo}` into `pc_next`, whatever the flags are.
- R4: Opcode 0x27 loads `{op_hi, op_lo}` into `pc_next` and pulses `stk_push` for exactly the `done` cycle, with `stk_wdata = pc_in + 3`. `stk_push` and `stk_pop` are never high together.
- R5: Opcode 0x28 pulses `stk_pop` during the cycle in which `start` is accepted. It then sets `pc_next` to the `stk_rdata` value present in that cycle.
- R6: Opcode 0x29 behaves as 0x28 and also raises `ie_restore` for the `done` cycle only.
- R7: Opcode 0x2A with an even pointer in `op_lo` drives `rf_raddr` to the pointer in the second cycle and to pointer+1 in the third cycle. `pc_next` becomes `{data at pointer+1, data at pointer}`. Outside these two cycles `rf_raddr` is 0.
- R8: Opcode 0x2A with an odd pointer raises `bad_ptr` together with `done` in the second cycle. It sets `pc_next` to `pc_in + 2`, performs no register read and no stack operation.
- R9: Counting the start cycle as cycle 1, `done` is high in cycle 3 for opcodes 0x20 to 0x27, in cycle 2 for 0x28/0x29, and in cycle 4 for an even-pointer 0x2A.
- R10: A `start` with an opcode outside 0x20 to 0x2A is ignored: no `done`, no stack strobe, and `pc_next` unchanged.
- R11: A `start` that arrives while an instruction is in progress is ignored.
- R12: While reset is asserted, `pc_next` is 0 and `done`, `stk_push`, `stk_pop`, `bad_ptr` and `ie_restore` are 0.
- R13: `done` lasts exactly one cycle. `pc_next` keeps its value after `done` until the next accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Instruction opcode |
| op_lo | input | 8 | First operand byte (target low byte or pointer) |
| op_hi | input | 8 | Second operand byte (target high byte) |
| pc_in | input | 16 | Address of the opcode byte |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| rf_raddr | output | 8 | Register-file read address |
| rf_rdata | input | 8 | Register-file read data (combinational from `rf_raddr`) |
| stk_rdata | input | 16 | Top-of-stack return address |
| stk_push | output | 1 | Push `stk_wdata` onto the stack |
| stk_pop | output | 1 | Pop the top of the stack |
| stk_wdata | output | 16 | Return address to push |
| pc_next | output | 16 | Computed next program counter |
| done | output | 1 | Completion strobe |
| bad_ptr | output | 1 | Odd indirect pointer, valid with `done` |
| ie_restore | output | 1 | Interrupt-enable restore strobe on interrupt return |

## Verification
The bench tests every conditional opcode with its flag both set and clear. If the flag tests or their polarities were swapped, jumps would be taken on the wrong condition. A not-taken jump placed near the top of memory shows whether `pc + 3` wraps. The completion cycle is measured per instruction class, so a stage that is missing or added shows up as `done` arriving early or late. The indirect jump is run with an even pointer and with an odd one. This catches swapped bytes in the assembled target, an odd pointer that still reads the register file or misreports `bad_ptr`, and a wrong fallback address. A call followed by a return and an interrupt return checks that the pushed value comes back. It also checks that `ie_restore` fires only on the interrupt return. Stray `start` pulses, both with undefined opcodes and during a running instruction, must leave `pc_next` and the stack untouched.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

    localparam logic [7:0] OPC_JC   = 8'h20;
    localparam logic [7:0] OPC_JNC  = 8'h21;
    localparam logic [7:0] OPC_JZ   = 8'h22;
    localparam logic [7:0] OPC_JNZ  = 8'h23;
    localparam logic [7:0] OPC_JS   = 8'h24;
    localparam logic [7:0] OPC_JNS  = 8'h25;
    localparam logic [7:0] OPC_JMP  = 8'h26;
    localparam logic [7:0] OPC_CALL = 8'h27;
    localparam logic [7:0] OPC_RET  = 8'h28;
    localparam logic [7:0] OPC_IRET = 8'h29;
    localparam logic [7:0] OPC_JMPR = 8'h2A;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_RDLO,
        ST_RDHI,
        ST_FIN
    } bsu_state_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_BRANCH,
        K_CALL,
        K_RET,
        K_IRET,
        K_IND
    } bsu_kind_e;

endpackage

// File: rtl/bsu_decode.sv
module bsu_decode
    import bsu_pkg::*;
#(
    parameter int OPC_W = 8
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic             flag_c,
    input  logic             flag_z,
    input  logic             flag_s,
    output bsu_kind_e        kind,
    output logic             taken
);

    always_comb begin
        kind  = K_NONE;
        taken = 1'b0;
        unique case (opcode)
            OPC_JC:   begin kind = K_BRANCH; taken =  flag_c; end
            OPC_JNC:  begin kind = K_BRANCH; taken = !flag_c; end
            OPC_JZ:   begin kind = K_BRANCH; taken =  flag_z; end
            OPC_JNZ:  begin kind = K_BRANCH; taken = !flag_z; end
            OPC_JS:   begin kind = K_BRANCH; taken =  flag_s; end
            OPC_JNS:  begin kind = K_BRANCH; taken = !flag_s; end
            OPC_JMP:  begin kind = K_BRANCH; taken = 1'b1;    end
            OPC_CALL: begin kind = K_CALL;   taken = 1'b1;    end
            OPC_RET:  kind = K_RET;
            OPC_IRET: kind = K_IRET;
            OPC_JMPR: kind = K_IND;
            default:  kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/bsu_ctrl_fsm.sv
module bsu_ctrl_fsm
    import bsu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  bsu_kind_e  kind,
    input  logic       ptr_odd,
    output bsu_state_e state,
    output logic       accept,
    output logic       done,
    output logic       push,
    output logic       pop,
    output logic       bad_ptr,
    output logic       ie_restore
);

    bsu_state_e nxt;
    bsu_kind_e  kind_q;
    logic       bad_q;

    assign accept = (state == ST_IDLE) && start && (kind != K_NONE);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    unique case (kind)
                        K_BRANCH, K_CALL: nxt = ST_HOLD;
                        K_RET, K_IRET:    nxt = ST_FIN;
                        K_IND:            nxt = ptr_odd ? ST_FIN : ST_RDLO;
                        default:          nxt = ST_IDLE;
                    endcase
                end
            end
            ST_HOLD: nxt = ST_FIN;
            ST_RDLO: nxt = ST_RDHI;
            ST_RDHI: nxt = ST_FIN;
            ST_FIN:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register with the instruction class latched at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            kind_q <= K_NONE;
            bad_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) begin
                kind_q <= kind;
                bad_q  <= (kind == K_IND) && ptr_odd;
            end
        end
    end

    // outputs
    always_comb begin
        done       = (state == ST_FIN);
        push       = done && (kind_q == K_CALL);
        ie_restore = done && (kind_q == K_IRET);
        bad_ptr    = done && bad_q;
        pop        = accept && ((kind == K_RET) || (kind == K_IRET));
    end

    p_done_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_branch_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (kind == K_BRANCH || kind == K_CALL)) |-> ##2 done);

    p_return_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (kind == K_RET || kind == K_IRET)) |=> done);

    p_ind_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == K_IND && !ptr_odd) |-> ##3 (done && !bad_ptr));

    p_odd_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == K_IND && ptr_odd) |=> (done && bad_ptr));

    p_rdhi_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDHI) |-> ($past(state) == ST_RDLO));

    p_no_push_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start) |=> ($past(state) != ST_FIN || state == ST_IDLE));

endmodule

// File: rtl/bsu_pc_path.sv
module bsu_pc_path
    import bsu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bsu_state_e        state,
    input  logic              accept,
    input  bsu_kind_e         kind,
    input  logic              taken,
    input  logic [DATA_W-1:0] op_lo,
    input  logic [DATA_W-1:0] op_hi,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] rf_rdata,
    input  logic [ADDR_W-1:0] stk_rdata,
    output logic [DATA_W-1:0] rf_raddr,
    output logic [ADDR_W-1:0] ret_addr,
    output logic [ADDR_W-1:0] pc_next
);

    localparam logic [ADDR_W-1:0] LEN_LONG = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] LEN_IND  = ADDR_W'(2);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] ret_q;
    logic [DATA_W-1:0] ptr_q;
    logic [DATA_W-1:0] lo_q;
    logic [ADDR_W-1:0] direct_tgt;
    logic [ADDR_W-1:0] seq_long;

    assign direct_tgt = {op_hi, op_lo};
    assign seq_long   = pc_in + LEN_LONG;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ret_q <= '0;
            ptr_q <= '0;
            lo_q  <= '0;
        end else begin
            if (accept) begin
                unique case (kind)
                    K_BRANCH: pc_q <= taken ? direct_tgt : seq_long;
                    K_CALL: begin
                        pc_q  <= direct_tgt;
                        ret_q <= seq_long;
                    end
                    K_RET, K_IRET: pc_q <= stk_rdata;
                    K_IND: begin
                        ptr_q <= op_lo;
                        if (op_lo[0]) pc_q <= pc_in + LEN_IND;
                    end
                    default: pc_q <= pc_q;
                endcase
            end
            if (state == ST_RDLO) lo_q <= rf_rdata;
            if (state == ST_RDHI) pc_q <= {rf_rdata, lo_q};
        end
    end

    always_comb begin
        unique case (state)
            ST_RDLO: rf_raddr = ptr_q;
            ST_RDHI: rf_raddr = {ptr_q[DATA_W-1:1], 1'b1};
            default: rf_raddr = '0;
        endcase
    end

    assign ret_addr = ret_q;
    assign pc_next  = pc_q;

    p_pc_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !accept) |=> $stable(pc_q));

    p_read_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDLO) |-> !rf_raddr[0]);

endmodule

// File: rtl/branch_seq_top.sv
module branch_seq_top
    import bsu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] opcode,
    input  logic [DATA_W-1:0] op_lo,
    input  logic [DATA_W-1:0] op_hi,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic              flag_c,
    input  logic              flag_z,
    input  logic              flag_s,
    output logic [DATA_W-1:0] rf_raddr,
    input  logic [DATA_W-1:0] rf_rdata,
    input  logic [ADDR_W-1:0] stk_rdata,
    output logic              stk_push,
    output logic              stk_pop,
    output logic [ADDR_W-1:0] stk_wdata,
    output logic [ADDR_W-1:0] pc_next,
    output logic              done,
    output logic              bad_ptr,
    output logic              ie_restore
);

    bsu_kind_e  kind;
    logic       taken;
    bsu_state_e state;
    logic       accept;

    bsu_decode #(.OPC_W(DATA_W)) u_dec (
        .opcode (opcode),
        .flag_c (flag_c),
        .flag_z (flag_z),
        .flag_s (flag_s),
        .kind   (kind),
        .taken  (taken)
    );

    bsu_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .kind       (kind),
        .ptr_odd    (op_lo[0]),
        .state      (state),
        .accept     (accept),
        .done       (done),
        .push       (stk_push),
        .pop        (stk_pop),
        .bad_ptr    (bad_ptr),
        .ie_restore (ie_restore)
    );

    bsu_pc_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .accept    (accept),
        .kind      (kind),
        .taken     (taken),
        .op_lo     (op_lo),
        .op_hi     (op_hi),
        .pc_in     (pc_in),
        .rf_rdata  (rf_rdata),
        .stk_rdata (stk_rdata),
        .rf_raddr  (rf_raddr),
        .ret_addr  (stk_wdata),
        .pc_next   (pc_next)
    );

    p_ie_only_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ie_restore |-> (done && !stk_push));

    p_push_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stk_push |=> !stk_push);

endmodule

// File: tb/branch_seq_top_tb.sv
module branch_seq_top_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0]  op;
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic [15:0] pc;
        logic [2:0]  czs;
        logic [15:0] exp_pc;
        logic [2:0]  exp_lat;
    } vec_t;

    // R1 R2 R3 R9: flags packed as {c,z,s}
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        {8'h20, 8'h34, 8'h12, 16'h0100, 3'b100, 16'h1234, 3'd3},
        {8'h20, 8'h34, 8'h12, 16'h0100, 3'b011, 16'h0103, 3'd3},
        {8'h21, 8'hAB, 8'hCD, 16'h2000, 3'b000, 16'hCDAB, 3'd3},
        {8'h21, 8'hAB, 8'hCD, 16'h2000, 3'b100, 16'h2003, 3'd3},
        {8'h22, 8'h00, 8'h40, 16'h3010, 3'b010, 16'h4000, 3'd3},
        {8'h22, 8'h00, 8'h40, 16'h3010, 3'b101, 16'h3013, 3'd3},
        {8'h23, 8'h55, 8'h05, 16'h0042, 3'b000, 16'h0555, 3'd3},
        {8'h23, 8'h55, 8'h05, 16'h0042, 3'b010, 16'h0045, 3'd3},
        {8'h24, 8'hEE, 8'h7F, 16'h1111, 3'b001, 16'h7FEE, 3'd3},
        {8'h24, 8'hEE, 8'h7F, 16'h1111, 3'b110, 16'h1114, 3'd3},
        {8'h25, 8'h01, 8'h80, 16'h0A00, 3'b110, 16'h8001, 3'd3},
        {8'h25, 8'h01, 8'h80, 16'h0A00, 3'b001, 16'h0A03, 3'd3},
        {8'h26, 8'h9A, 8'hBC, 16'h5555, 3'b111, 16'hBC9A, 3'd3},
        {8'h20, 8'h00, 8'h00, 16'hFFFE, 3'b000, 16'h0001, 3'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [7:0]  op_lo = 8'h00;
    logic [7:0]  op_hi = 8'h00;
    logic [15:0] pc_in = 16'h0000;
    logic        flag_c = 1'b0;
    logic        flag_z = 1'b0;
    logic        flag_s = 1'b0;
    logic [7:0]  rf_raddr;
    logic [7:0]  rf_rdata;
    logic [15:0] stk_rdata;
    logic        stk_push;
    logic        stk_pop;
    logic [15:0] stk_wdata;
    logic [15:0] pc_next;
    logic        done;
    logic        bad_ptr;
    logic        ie_restore;

    int checks = 0;
    int errors = 0;

    logic [7:0]  rf_mem [256];
    logic [15:0] stk_mem [8];
    int          sp = 0;
    int          pops_seen = 0;
    int          pushes_seen = 0;

    int          lat;
    logic        got_done;
    logic [15:0] cap_pc;
    logic        cap_push, cap_pop, cap_ie, cap_bad;
    logic [15:0] cap_wdata;
    logic [7:0]  ra_log [10];

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign rf_rdata  = rf_mem[rf_raddr];
    assign stk_rdata = (sp > 0) ? stk_mem[sp - 1] : 16'hDEAD;

    always @(posedge clk) begin
        if (stk_push) begin
            stk_mem[sp] <= stk_wdata;
            sp <= sp + 1;
            pushes_seen <= pushes_seen + 1;
        end else if (stk_pop) begin
            if (sp > 0) sp <= sp - 1;
            pops_seen <= pops_seen + 1;
        end
    end

    branch_seq_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .opcode     (opcode),
        .op_lo      (op_lo),
        .op_hi      (op_hi),
        .pc_in      (pc_in),
        .flag_c     (flag_c),
        .flag_z     (flag_z),
        .flag_s     (flag_s),
        .rf_raddr   (rf_raddr),
        .rf_rdata   (rf_rdata),
        .stk_rdata  (stk_rdata),
        .stk_push   (stk_push),
        .stk_pop    (stk_pop),
        .stk_wdata  (stk_wdata),
        .pc_next    (pc_next),
        .done       (done),
        .bad_ptr    (bad_ptr),
        .ie_restore (ie_restore)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // drive one instruction; cycle 1 is the start cycle
    task automatic issue(input logic [7:0] op, input logic [7:0] lo, input logic [7:0] hi,
                         input logic [15:0] pc, input logic [2:0] czs);
        @(negedge clk);
        opcode = op; op_lo = lo; op_hi = hi; pc_in = pc;
        {flag_c, flag_z, flag_s} = czs;
        start = 1'b1;
        #1;
        cap_pop = stk_pop;
        ra_log[1] = rf_raddr;
        @(negedge clk);
        start = 1'b0;
        lat = 2;
        ra_log[2] = rf_raddr;
        while (!done && lat < 8) begin
            @(negedge clk);
            lat++;
            ra_log[lat] = rf_raddr;
        end
        got_done  = done;
        cap_pc    = pc_next;
        cap_push  = stk_push;
        cap_wdata = stk_wdata;
        cap_ie    = ie_restore;
        cap_bad   = bad_ptr;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) rf_mem[i] = 8'(i * 7 + 3);
        rf_mem[8'h40] = 8'h78; rf_mem[8'h41] = 8'h56;

        // R12: reset state
        repeat (3) @(negedge clk);
        chk(pc_next == 16'h0, "R12 pc_next", pc_next, 0);
        chk({done, stk_push, stk_pop, bad_ptr, ie_restore} == 5'b0, "R12 strobes",
            {done, stk_push, stk_pop, bad_ptr, ie_restore}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R3 R9: vector table
        for (int v = 0; v < NV; v++) begin
            issue(VECS[v].op, VECS[v].lo, VECS[v].hi, VECS[v].pc, VECS[v].czs);
            chk(got_done && cap_pc == VECS[v].exp_pc, $sformatf("R1/R2/R3 vec %0d pc", v),
                cap_pc, VECS[v].exp_pc);
            chk(lat == int'(VECS[v].exp_lat), $sformatf("R9 vec %0d latency", v),
                lat, VECS[v].exp_lat);
            // R13: done lasts one cycle, pc holds
            @(negedge clk);
            chk(!done && pc_next == VECS[v].exp_pc, $sformatf("R13 vec %0d hold", v),
                {done, pc_next}, {1'b0, VECS[v].exp_pc});
        end

        // R4: call
        issue(8'h27, 8'h00, 8'h30, 16'h0200, 3'b000);
        chk(cap_pc == 16'h3000, "R4 call target", cap_pc, 16'h3000);
        chk(cap_push && cap_wdata == 16'h0203, "R4 push value", {cap_push, cap_wdata}, {1'b1, 16'h0203});
        chk(lat == 3 && !cap_pop && !cap_ie, "R4 R9 call timing", lat, 3);
        @(negedge clk);
        chk(!stk_push && pushes_seen == 1, "R4 single push", pushes_seen, 1);

        // R5: return
        issue(8'h28, 8'h00, 8'h00, 16'h3005, 3'b000);
        chk(cap_pop, "R5 pop in start cycle", cap_pop, 1);
        chk(cap_pc == 16'h0203, "R5 return target", cap_pc, 16'h0203);
        chk(lat == 2 && !cap_ie && !cap_push, "R5 R9 return timing", lat, 2);
        chk(pops_seen == 1 && sp == 0, "R5 one pop", pops_seen, 1);

        // R6: interrupt return
        issue(8'h27, 8'hC0, 8'h0F, 16'h0777, 3'b000);
        issue(8'h29, 8'h00, 8'h00, 16'h0FC0, 3'b000);
        chk(cap_pop && cap_pc == 16'h077A, "R6 iret target", cap_pc, 16'h077A);
        chk(cap_ie && lat == 2, "R6 ie_restore with done", {cap_ie, 4'(lat)}, {1'b1, 4'd2});
        @(negedge clk);
        chk(!ie_restore, "R6 ie_restore ends", ie_restore, 0);

        // R7: indirect jump, even pointer
        issue(8'h2A, 8'h40, 8'h00, 16'h0900, 3'b000);
        chk(cap_pc == 16'h5678, "R7 indirect target", cap_pc, 16'h5678);
        chk(ra_log[2] == 8'h40 && ra_log[3] == 8'h41, "R7 read order",
            {ra_log[2], ra_log[3]}, 16'h4041);
        chk(ra_log[1] == 8'h00 && ra_log[4] == 8'h00, "R7 raddr idle",
            {ra_log[1], ra_log[4]}, 0);
        chk(lat == 4 && !cap_bad, "R9 indirect latency", lat, 4);

        // R8: odd pointer
        issue(8'h2A, 8'h41, 8'h00, 16'h0900, 3'b000);
        chk(cap_bad && lat == 2, "R8 bad_ptr timing", {cap_bad, 4'(lat)}, {1'b1, 4'd2});
        chk(cap_pc == 16'h0902, "R8 fallback pc", cap_pc, 16'h0902);
        chk(ra_log[1] == 0 && ra_log[2] == 0 && !cap_push && !cap_pop, "R8 no access",
            {ra_log[1], ra_log[2]}, 0);

        // R10: undefined opcodes
        issue(8'h2B, 8'h11, 8'h22, 16'h4444, 3'b111);
        chk(!got_done && pc_next == 16'h0902 && !cap_pop, "R10 opcode 0x2B", pc_next, 16'h0902);
        issue(8'h1F, 8'h11, 8'h22, 16'h4444, 3'b111);
        chk(!got_done && pc_next == 16'h0902, "R10 opcode 0x1F", pc_next, 16'h0902);

        // R11: start during a running jump
        @(negedge clk);
        opcode = 8'h26; op_lo = 8'h22; op_hi = 8'h11; pc_in = 16'h0010; start = 1'b1;
        @(negedge clk);
        opcode = 8'h28;
        #1;
        chk(!stk_pop, "R11 no pop while busy", stk_pop, 0);
        @(negedge clk);
        start = 1'b0;
        chk(done && pc_next == 16'h1122, "R11 first instruction completes", pc_next, 16'h1122);
        @(negedge clk);
        @(negedge clk);
        chk(!done && pc_next == 16'h1122 && pops_seen == 2, "R11 busy start ignored",
            {done, pc_next}, {1'b0, 16'h1122});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule